// File: doc/BRIEF.md
# JTAG Debug Memory Access Sequencer

This block is a hardware master for the 4-wire JTAG debug port of a 16-bit microcontroller target. A separate target clock line is also driven. A single request names one debug operation:

- reset the TAP controller,
- halt the CPU,
- release the CPU,
- wait for an instruction fetch,
- set the program counter,
- read a word or byte of memory,
- write a word or byte of memory,
- pulse the CPU reset.

The sequencer expands the request into a fixed script. The script is a series of 8-bit instruction scans and 16-bit data scans, with target-clock edges placed between the scans. It walks the TAP state machine itself and returns the value captured in the last data scan together with a one-cycle done pulse.

TCK is generated by dividing the system clock. Each TCK phase lasts `TCK_HALF` system cycles. TMS and TDI move only while TCK is low, and TDO is taken at the rising edge of TCK. The instruction opcodes are parameters. The poll that waits for an instruction fetch gives up after `POLL_MAX` attempts and raises an error instead of hanging.

Top module: `jdbg_seq_top`

## Requirements
- R1: After reset: `jtck`=0, `jtms`=1, `jtdi`=0, `jtclk`=1, `req_ready`=1 and `rsp_done`=0.
- R2: Each TCK pulse is low for at least `TCK_HALF` system cycles and high for exactly `TCK_HALF` cycles. TMS and TDI never change while TCK is high, and TCK rests low between scans.
- R3: An instruction scan starts from Run-Test/Idle. It uses TMS 1,1,0,0, then shifts 8 opcode bits least significant bit first, with TMS=1 on the last bit. It then uses TMS 1,0 and ends in Run-Test/Idle.
- R4: A data scan starts from Run-Test/Idle with TMS 1,0,0. It then shifts 16 bits most significant bit first, capturing TDO most significant bit first, with TMS=1 on the last bit. It then uses TMS 1,0. `rsp_data` holds the last captured 16-bit value.
- R5: Command 0 (TAP reset) drives TMS=1 for `RST_ONES` (at least 6) TCK cycles and then one cycle of TMS=0, ending in Run-Test/Idle.
- R6: Command 1 (halt) performs these steps in order: data-16 instruction, data 0x3FFF, target clock low, control instruction, data 0x2409, target clock high.
- R7: Command 2 (release) performs three steps: control instruction, data 0x2401, address-capture instruction.
- R8: Command 4 (set PC) performs these steps in order:
  - control instruction, 0x3401
  - data-16 instruction, 0x4030
  - clock low, clock high
  - the address from `req_addr`
  - clock low, clock high
  - address-capture instruction, clock low
  - control instruction, 0x2401
  - clock high
- R9: Command 5 (read) performs these steps in order: clock low, control instruction, control word (0x2409 word, or 0x2419 when `req_byte`=1), address-16 instruction, address, data-to-address instruction, clock high, clock low, a 0x0000 data scan, clock high. `rsp_data` returns the value captured by the final data scan.
- R10: Command 6 (write) performs these steps in order: clock low, control instruction, control word (0x2408 word, or 0x2418 when `req_byte`=1), address-16 instruction, address, data-to-address instruction, the data from `req_wdata`, clock high.
- R11: Command 3 (fetch wait) loads the control-capture instruction. It then repeats 0x0000 data scans until bit 7 of a captured value is 1, and finishes without error with that value in `rsp_data`.
- R12: If `POLL_MAX` fetch polls all return bit 7 = 0, the command ends with exactly `POLL_MAX` polls and `rsp_err`=1, raised together with `rsp_done`.
- R13: Command 7 (CPU reset) performs a control instruction followed by data 0x2C01 and then data 0x2401.
- R14: A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the command ends. `rsp_done` is a one-cycle pulse during which `req_ready` is 0, and `req_ready` returns to 1 on the next cycle. `rsp_err` is cleared when a new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | sequencer idle, request will be taken |
| req_cmd | input | 3 | command code (see R5 to R13) |
| req_byte | input | 1 | byte access instead of word for read/write |
| req_addr | input | 16 | memory address or program counter value |
| req_wdata | input | 16 | write data |
| rsp_done | output | 1 | one-cycle end-of-command pulse |
| rsp_data | output | 16 | last captured data-scan value |
| rsp_err | output | 1 | fetch poll exhausted |
| jtck | output | 1 | JTAG test clock |
| jtms | output | 1 | JTAG mode select |
| jtdi | output | 1 | JTAG data to target |
| jtdo | input | 1 | JTAG data from target |
| jtclk | output | 1 | target clock line |

## Verification
A command's results are due only on the cycle of `rsp_done`. That cycle follows the final scan by one system cycle when the script ends in a scan, or follows the last target-clock step when the script ends in one. The bench therefore waits for that pulse on falling system-clock edges. At that edge it compares `rsp_data` and `rsp_err`, and it compares the scan log built by its own TAP target model against the script it computes for the command.

Individual TCK and TDO timing is not sampled at fixed offsets. A monitor measures every TCK phase length in system cycles and watches TMS and TDI while TCK is high. The handshake is checked on the falling edges right after acceptance and right after `rsp_done`.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;
  parameter int IR_BITS = 8;
  parameter int DR_BITS = 16;
  parameter int SLOT_W  = 32;
  localparam int IR_SLOTS = IR_BITS + 6;
  localparam int DR_SLOTS = DR_BITS + 5;

  localparam logic [DR_BITS-1:0] CW_READ_W  = 16'h2409;
  localparam logic [DR_BITS-1:0] CW_READ_B  = 16'h2419;
  localparam logic [DR_BITS-1:0] CW_WRITE_W = 16'h2408;
  localparam logic [DR_BITS-1:0] CW_WRITE_B = 16'h2418;
  localparam logic [DR_BITS-1:0] CW_RELEASE = 16'h2401;
  localparam logic [DR_BITS-1:0] CW_PC_FREE = 16'h3401;
  localparam logic [DR_BITS-1:0] CW_RST_ON  = 16'h2C01;
  localparam logic [DR_BITS-1:0] OP_SELFJMP = 16'h3FFF;
  localparam logic [DR_BITS-1:0] OP_LOADPC  = 16'h4030;
  localparam int FETCH_BIT = 7;

  typedef enum logic [2:0] {
    K_END, K_RST, K_IR, K_DR, K_POLL, K_TLO, K_THI
  } step_kind_e;

  typedef enum logic [2:0] {
    C_TAPRST = 3'd0, C_HALT = 3'd1, C_RELEASE = 3'd2, C_FETCH = 3'd3,
    C_SETPC = 3'd4, C_READ = 3'd5, C_WRITE = 3'd6, C_CPURST = 3'd7
  } cmd_e;

  typedef struct packed {
    step_kind_e         kind;
    logic [DR_BITS-1:0] val;
  } step_t;

  typedef struct packed {
    logic [SLOT_W-1:0] tms;
    logic [SLOT_W-1:0] tdi;
    logic [SLOT_W-1:0] dmask;
    logic [5:0]        len;
  } scan_pat_t;

  // Slot-by-slot TMS/TDI pattern of one scan, starting and ending in Run-Test/Idle.
  function automatic scan_pat_t build_scan(step_kind_e kind, logic [DR_BITS-1:0] val,
                                           logic [5:0] rst_ones);
    scan_pat_t p;
    p = '0;
    case (kind)
      K_RST: begin
        for (int i = 0; i < SLOT_W; i++)
          if (i < int'(rst_ones)) p.tms[i] = 1'b1;
        p.len = rst_ones + 6'd1;
      end
      K_IR: begin
        p.tms[0] = 1'b1;
        p.tms[1] = 1'b1;
        for (int k = 0; k < IR_BITS; k++) p.tdi[4+k] = val[k];
        p.tms[4+IR_BITS-1] = 1'b1;
        p.tms[4+IR_BITS]   = 1'b1;
        p.len = 6'(IR_SLOTS);
      end
      K_DR, K_POLL: begin
        p.tms[0] = 1'b1;
        for (int k = 0; k < DR_BITS; k++) begin
          p.tdi[3+k]   = val[DR_BITS-1-k];
          p.dmask[3+k] = 1'b1;
        end
        p.tms[3+DR_BITS-1] = 1'b1;
        p.tms[3+DR_BITS]   = 1'b1;
        p.len = 6'(DR_SLOTS);
      end
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/jdbg_scan_engine.sv
module jdbg_scan_engine
  import jdbg_pkg::*;
#(
  parameter int TCK_HALF = 2,
  parameter int RST_ONES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  step_kind_e         kind,
  input  logic [DR_BITS-1:0] val,
  input  logic               tdo,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  output logic               busy,
  output logic               fin,
  output logic [DR_BITS-1:0] cap
);
  localparam int CW = $clog2(2*TCK_HALF) + 1;
  localparam logic [CW-1:0] RISE_AT = CW'(TCK_HALF - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(2*TCK_HALF - 1);

  scan_pat_t pat, pat_new;
  logic [CW-1:0] cnt;
  logic [4:0]    slot;
  logic [4:0]    slot_nx;
  logic          rise_ev, fall_ev, last_slot;

  assign pat_new   = build_scan(kind, val, 6'(RST_ONES));
  assign rise_ev   = busy && (cnt == RISE_AT);
  assign fall_ev   = busy && (cnt == FALL_AT);
  assign last_slot = ({1'b0, slot} == pat.len - 6'd1);
  assign slot_nx   = slot + 5'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; slot <= '0; pat <= '0;
      tck <= 1'b0; tms <= 1'b1; tdi <= 1'b0; cap <= '0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (start) begin
          pat  <= pat_new;
          busy <= 1'b1;
          cnt  <= '0;
          slot <= '0;
          tck  <= 1'b0;
          tms  <= pat_new.tms[0];
          tdi  <= pat_new.tdi[0];
        end
      end else begin
        if (rise_ev) begin
          tck <= 1'b1;
          if (pat.dmask[slot]) cap <= {cap[DR_BITS-2:0], tdo};
        end
        if (fall_ev) begin
          cnt <= '0;
          tck <= 1'b0;
          if (last_slot) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            slot <= slot_nx;
            tms  <= pat.tms[slot_nx];
            tdi  <= pat.tdi[slot_nx];
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  a_r2_pins_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
  a_r14_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/jdbg_cmd_seq.sv
module jdbg_cmd_seq
  import jdbg_pkg::*;
#(
  parameter int POLL_MAX = 50,
  parameter logic [IR_BITS-1:0] IR_CTL   = 8'h13,
  parameter logic [IR_BITS-1:0] IR_CTLCAP = 8'h14,
  parameter logic [IR_BITS-1:0] IR_DAT   = 8'h41,
  parameter logic [IR_BITS-1:0] IR_ADR   = 8'h83,
  parameter logic [IR_BITS-1:0] IR_D2A   = 8'h85,
  parameter logic [IR_BITS-1:0] IR_ACAP  = 8'h84
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_cmd,
  input  logic               req_byte,
  input  logic [DR_BITS-1:0] req_addr,
  input  logic [DR_BITS-1:0] req_wdata,
  output logic               rsp_done,
  output logic [DR_BITS-1:0] rsp_data,
  output logic               rsp_err,
  output logic               tclk,
  output logic               eng_start,
  output step_kind_e         eng_kind,
  output logic [DR_BITS-1:0] eng_val,
  input  logic               eng_fin,
  input  logic [DR_BITS-1:0] eng_cap
);
  localparam int PW = $clog2(POLL_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e                state;
  cmd_e               cmd_q;
  logic               byte_q;
  logic [DR_BITS-1:0] addr_q, data_q;
  logic [3:0]         idx;
  logic [PW-1:0]      polls;
  step_t              step;
  logic               poll_hit, poll_last;

  function automatic step_t mk(step_kind_e k, logic [DR_BITS-1:0] v);
    step_t s;
    s.kind = k;
    s.val  = v;
    return s;
  endfunction

  function automatic step_t ir(logic [IR_BITS-1:0] op);
    return mk(K_IR, DR_BITS'(op));
  endfunction

  // Fixed script of each command, one step per index; K_END closes it.
  function automatic step_t script_step(cmd_e c, logic [3:0] i, logic b,
                                        logic [DR_BITS-1:0] a, logic [DR_BITS-1:0] d);
    step_t s;
    s = mk(K_END, '0);
    case (c)
      C_TAPRST: if (i == 0) s = mk(K_RST, '0);
      C_HALT: case (i)
        4'd0: s = ir(IR_DAT);        4'd1: s = mk(K_DR, OP_SELFJMP);
        4'd2: s = mk(K_TLO, '0);     4'd3: s = ir(IR_CTL);
        4'd4: s = mk(K_DR, CW_READ_W); 4'd5: s = mk(K_THI, '0);
        default: ;
      endcase
      C_RELEASE: case (i)
        4'd0: s = ir(IR_CTL); 4'd1: s = mk(K_DR, CW_RELEASE); 4'd2: s = ir(IR_ACAP);
        default: ;
      endcase
      C_FETCH: case (i)
        4'd0: s = ir(IR_CTLCAP); 4'd1: s = mk(K_POLL, '0);
        default: ;
      endcase
      C_SETPC: case (i)
        4'd0: s = ir(IR_CTL);        4'd1: s = mk(K_DR, CW_PC_FREE);
        4'd2: s = ir(IR_DAT);        4'd3: s = mk(K_DR, OP_LOADPC);
        4'd4: s = mk(K_TLO, '0);     4'd5: s = mk(K_THI, '0);
        4'd6: s = mk(K_DR, a);       4'd7: s = mk(K_TLO, '0);
        4'd8: s = mk(K_THI, '0);     4'd9: s = ir(IR_ACAP);
        4'd10: s = mk(K_TLO, '0);    4'd11: s = ir(IR_CTL);
        4'd12: s = mk(K_DR, CW_RELEASE); 4'd13: s = mk(K_THI, '0);
        default: ;
      endcase
      C_READ: case (i)
        4'd0: s = mk(K_TLO, '0);     4'd1: s = ir(IR_CTL);
        4'd2: s = mk(K_DR, b ? CW_READ_B : CW_READ_W);
        4'd3: s = ir(IR_ADR);        4'd4: s = mk(K_DR, a);
        4'd5: s = ir(IR_D2A);        4'd6: s = mk(K_THI, '0);
        4'd7: s = mk(K_TLO, '0);     4'd8: s = mk(K_DR, '0);
        4'd9: s = mk(K_THI, '0);
        default: ;
      endcase
      C_WRITE: case (i)
        4'd0: s = mk(K_TLO, '0);     4'd1: s = ir(IR_CTL);
        4'd2: s = mk(K_DR, b ? CW_WRITE_B : CW_WRITE_W);
        4'd3: s = ir(IR_ADR);        4'd4: s = mk(K_DR, a);
        4'd5: s = ir(IR_D2A);        4'd6: s = mk(K_DR, d);
        4'd7: s = mk(K_THI, '0);
        default: ;
      endcase
      C_CPURST: case (i)
        4'd0: s = ir(IR_CTL); 4'd1: s = mk(K_DR, CW_RST_ON); 4'd2: s = mk(K_DR, CW_RELEASE);
        default: ;
      endcase
      default: ;
    endcase
    return s;
  endfunction

  assign step      = script_step(cmd_q, idx, byte_q, addr_q, data_q);
  assign eng_kind  = step.kind;
  assign eng_val   = step.val;
  assign eng_start = (state == S_ISSUE) &&
                     (step.kind inside {K_RST, K_IR, K_DR, K_POLL});
  assign poll_hit  = eng_cap[FETCH_BIT];
  assign poll_last = (polls == PW'(POLL_MAX - 1));
  assign req_ready = (state == S_IDLE);
  assign rsp_done  = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cmd_q <= C_TAPRST; byte_q <= 1'b0; addr_q <= '0; data_q <= '0;
      idx <= '0; polls <= '0; rsp_data <= '0; rsp_err <= 1'b0; tclk <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cmd_q   <= cmd_e'(req_cmd);
          byte_q  <= req_byte;
          addr_q  <= req_addr;
          data_q  <= req_wdata;
          idx     <= '0;
          polls   <= '0;
          rsp_err <= 1'b0;
          state   <= S_ISSUE;
        end
        S_ISSUE: case (step.kind)
          K_END: state <= S_DONE;
          K_TLO: begin tclk <= 1'b0; idx <= idx + 4'd1; end
          K_THI: begin tclk <= 1'b1; idx <= idx + 4'd1; end
          default: state <= S_WAIT;
        endcase
        S_WAIT: if (eng_fin) begin
          state <= S_ISSUE;
          if (step.kind inside {K_DR, K_POLL}) rsp_data <= eng_cap;
          if (step.kind == K_POLL) begin
            if (poll_hit) idx <= idx + 4'd1;
            else if (poll_last) begin
              rsp_err <= 1'b1;
              state   <= S_DONE;
            end else polls <= polls + PW'(1);
          end else idx <= idx + 4'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r12_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    polls < PW'(POLL_MAX));
  a_r12_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_err) |-> rsp_done);
  a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));
  a_r14_no_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !eng_start);
endmodule

// File: rtl/jdbg_seq_top.sv
module jdbg_seq_top
  import jdbg_pkg::*;
#(
  parameter int TCK_HALF = 2,
  parameter int RST_ONES = 6,
  parameter int POLL_MAX = 50,
  parameter logic [7:0] IR_CTL    = 8'h13,
  parameter logic [7:0] IR_CTLCAP = 8'h14,
  parameter logic [7:0] IR_DAT    = 8'h41,
  parameter logic [7:0] IR_ADR    = 8'h83,
  parameter logic [7:0] IR_D2A    = 8'h85,
  parameter logic [7:0] IR_ACAP   = 8'h84
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_cmd,
  input  logic        req_byte,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic [15:0] rsp_data,
  output logic        rsp_err,
  output logic        jtck,
  output logic        jtms,
  output logic        jtdi,
  input  logic        jtdo,
  output logic        jtclk
);
  logic               eng_start, eng_busy, eng_fin;
  step_kind_e         eng_kind;
  logic [DR_BITS-1:0] eng_val, eng_cap;

  jdbg_cmd_seq #(
    .POLL_MAX(POLL_MAX), .IR_CTL(IR_CTL), .IR_CTLCAP(IR_CTLCAP), .IR_DAT(IR_DAT),
    .IR_ADR(IR_ADR), .IR_D2A(IR_D2A), .IR_ACAP(IR_ACAP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_err(rsp_err), .tclk(jtclk),
    .eng_start(eng_start), .eng_kind(eng_kind), .eng_val(eng_val),
    .eng_fin(eng_fin), .eng_cap(eng_cap)
  );

  jdbg_scan_engine #(.TCK_HALF(TCK_HALF), .RST_ONES(RST_ONES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind), .val(eng_val),
    .tdo(jtdo), .tck(jtck), .tms(jtms), .tdi(jtdi), .busy(eng_busy),
    .fin(eng_fin), .cap(eng_cap)
  );

  a_r14_fin_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> eng_busy);
  a_r12_done_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !eng_busy);
endmodule

// File: tb/jdbg_seq_top_test.sv
module jdbg_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int RONES = 6;
  localparam int PMAX = 50;
  localparam logic [7:0] I_CTL = 8'h13, I_CCAP = 8'h14, I_DAT = 8'h41,
                         I_ADR = 8'h83, I_D2A = 8'h85, I_ACAP = 8'h84;
  localparam int T_END = 0, T_RST = 1, T_IR = 2, T_DR = 3, T_CLK = 4;

  logic clk = 0, rst_n = 0, req_valid = 0, req_byte = 0, jtdo = 0;
  logic [2:0] req_cmd = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_done, rsp_err, jtck, jtms, jtdi, jtclk;
  logic [15:0] rsp_data;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jdbg_seq_top #(.TCK_HALF(HALF), .RST_ONES(RONES), .POLL_MAX(PMAX),
    .IR_CTL(I_CTL), .IR_CTLCAP(I_CCAP), .IR_DAT(I_DAT), .IR_ADR(I_ADR),
    .IR_D2A(I_D2A), .IR_ACAP(I_ACAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_err(rsp_err), .jtck(jtck),
    .jtms(jtms), .jtdi(jtdi), .jtdo(jtdo), .jtclk(jtclk));

  // ---------------- target model ----------------
  localparam logic [3:0] TLR=0, RTI=1, SELDR=2, CAPDR=3, SHDR=4, EX1DR=5, PADR=6, EX2DR=7,
    UPDR=8, SELIR=9, CAPIR=10, SHIR=11, EX1IR=12, PAIR=13, EX2IR=14, UPIR=15;
  logic [3:0] tst = RTI;
  logic [7:0] isr = 0, m_ir = 0;
  logic [15:0] dsr = 0, m_addr = 0, m_ctl = 0;
  int m_polls = 0, ready_at = 0, tms_ones = 0, tck_edges = 0;
  int log_n = 0;
  int log_t [64];
  logic [15:0] log_v [64];
  bit log_en = 0;

  function automatic logic [3:0] nxt(logic [3:0] s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;      RTI: return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR; CAPDR: return m ? EX1DR : SHDR;
      SHDR: return m ? EX1DR : SHDR;  EX1DR: return m ? UPDR : PADR;
      PADR: return m ? EX2DR : PADR;  EX2DR: return m ? UPDR : SHDR;
      UPDR: return m ? SELDR : RTI;   SELIR: return m ? TLR : CAPIR;
      CAPIR: return m ? EX1IR : SHIR; SHIR: return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR : PAIR;  PAIR: return m ? EX2IR : PAIR;
      EX2IR: return m ? UPIR : SHIR;  default: return m ? SELDR : RTI;
    endcase
  endfunction

  function automatic logic [15:0] pat(logic [15:0] a);
    return a ^ 16'h5AC3;
  endfunction

  task automatic log_add(int t, logic [15:0] v);
    if (log_en && log_n < 64) begin
      log_t[log_n] = t; log_v[log_n] = v; log_n++;
    end
  endtask

  always @(posedge jtck) begin
    logic [3:0] ns;
    tck_edges++;
    if (jtms) tms_ones++;
    case (tst)
      CAPDR: begin
        if (m_ir == I_D2A) dsr = m_ctl[4] ? {8'h00, pat(m_addr)[7:0]} : pat(m_addr);
        else if (m_ir == I_CCAP) begin
          dsr = (m_polls >= ready_at) ? 16'h0280 : 16'h0201;
          m_polls++;
        end else dsr = 16'h0000;
      end
      SHDR: dsr = {dsr[14:0], jtdi};
      CAPIR: isr = 8'h01;
      SHIR: isr = {jtdi, isr[7:1]};
      UPDR: begin
        log_add(T_DR, dsr);
        if (m_ir == I_ADR) m_addr = dsr;
        if (m_ir == I_CTL) m_ctl = dsr;
      end
      UPIR: begin m_ir = isr; log_add(T_IR, {8'h00, isr}); end
      default: ;
    endcase
    ns = nxt(tst, jtms);
    if (ns == TLR && tst != TLR) log_add(T_RST, 16'h0);
    tst = ns;
  end

  always @(negedge jtck)
    jtdo <= (tst == SHDR) ? dsr[15] : (tst == SHIR) ? isr[0] : 1'b0;

  always @(jtclk) log_add(T_CLK, {15'h0, jtclk});

  // ---------------- TCK timing monitor (R2) ----------------
  int run = 0, viol = 0;
  logic p_tck = 0, p_tms = 1, p_tdi = 0;
  always @(negedge clk) if (rst_n) begin
    cycles++;
    if (jtck != p_tck) begin
      if (p_tck && run != HALF) viol++;
      if (!p_tck && run < HALF) viol++;
      run = 1;
    end else begin
      run++;
      if (jtck && (jtms != p_tms || jtdi != p_tdi)) viol++;
    end
    p_tck = jtck; p_tms = jtms; p_tdi = jtdi;
  end

  // ---------------- expected scripts ----------------
  int ex_t [16];
  logic [15:0] ex_v [16];
  int ex_n;

  task automatic ea(int t, logic [15:0] v);
    ex_t[ex_n] = t; ex_v[ex_n] = v; ex_n++;
  endtask

  task automatic build_exp(int c, bit b, logic [15:0] a, logic [15:0] d);
    ex_n = 0;
    case (c)
      0: ea(T_RST, 0);
      1: begin ea(T_IR, I_DAT); ea(T_DR, 16'h3FFF); ea(T_CLK, 0); ea(T_IR, I_CTL);
               ea(T_DR, 16'h2409); ea(T_CLK, 1); end
      2: begin ea(T_IR, I_CTL); ea(T_DR, 16'h2401); ea(T_IR, I_ACAP); end
      4: begin ea(T_IR, I_CTL); ea(T_DR, 16'h3401); ea(T_IR, I_DAT); ea(T_DR, 16'h4030);
               ea(T_CLK, 0); ea(T_CLK, 1); ea(T_DR, a); ea(T_CLK, 0); ea(T_CLK, 1);
               ea(T_IR, I_ACAP); ea(T_CLK, 0); ea(T_IR, I_CTL); ea(T_DR, 16'h2401);
               ea(T_CLK, 1); end
      5: begin ea(T_CLK, 0); ea(T_IR, I_CTL); ea(T_DR, b ? 16'h2419 : 16'h2409);
               ea(T_IR, I_ADR); ea(T_DR, a); ea(T_IR, I_D2A); ea(T_CLK, 1); ea(T_CLK, 0);
               ea(T_DR, 16'h0000); ea(T_CLK, 1); end
      6: begin ea(T_CLK, 0); ea(T_IR, I_CTL); ea(T_DR, b ? 16'h2418 : 16'h2408);
               ea(T_IR, I_ADR); ea(T_DR, a); ea(T_IR, I_D2A); ea(T_DR, d); ea(T_CLK, 1); end
      7: begin ea(T_IR, I_CTL); ea(T_DR, 16'h2C01); ea(T_DR, 16'h2401); end
      default: ;
    endcase
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(int c, bit b, logic [15:0] a, logic [15:0] d, int rdy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    log_n = 0; m_polls = 0; ready_at = rdy; tms_ones = 0; tck_edges = 0;
    req_cmd = 3'(c); req_byte = b; req_addr = a; req_wdata = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && !rsp_done, "R14", "busy after accept", {30'd0, req_ready, rsp_done}, 0);
    while (!rsp_done) @(negedge clk);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(req_ready && !rsp_done, "R14", "ready after done", {30'd0, req_ready, rsp_done}, 32'h2);
  endtask

  task automatic run_script(int c, bit b, logic [15:0] a, logic [15:0] d, string req);
    int bad;
    issue(c, b, a, d, 0);
    build_exp(c, b, a, d);
    bad = (log_n != ex_n) ? 1 : 0;
    for (int i = 0; i < ex_n && i < log_n; i++)
      if (log_t[i] != ex_t[i] || log_v[i] != ex_v[i]) bad = 1;
    chk(bad == 0, req, "scan script", {16'(log_n), log_n > 0 ? log_v[log_n-1] : 16'h0},
        {16'(ex_n), ex_n > 0 ? ex_v[ex_n-1] : 16'h0});
    chk(!rsp_err, req, "no error", {31'd0, rsp_err}, 0);
    if (c == 5) chk(rsp_data == (b ? {8'h00, pat(a)[7:0]} : pat(a)), "R9", "read data",
                    {16'd0, rsp_data}, {16'd0, b ? {8'h00, pat(a)[7:0]} : pat(a)});
    after_done();
  endtask

  task automatic run_fetch(int rdy);
    int npoll, exp_n, bad;
    bit exp_err;
    issue(3, 0, 0, 0, rdy);
    exp_err = (rdy >= PMAX);
    exp_n = exp_err ? PMAX : rdy + 1;
    npoll = 0; bad = 0;
    if (log_n < 1 || log_t[0] != T_IR || log_v[0] != {8'h00, I_CCAP}) bad = 1;
    for (int i = 1; i < log_n; i++) begin
      if (log_t[i] != T_DR || log_v[i] != 16'h0) bad = 1;
      npoll++;
    end
    chk(bad == 0 && npoll == exp_n, exp_err ? "R12" : "R11", "poll count",
        32'(npoll), 32'(exp_n));
    chk(rsp_err == exp_err, exp_err ? "R12" : "R11", "error flag",
        {31'd0, rsp_err}, {31'd0, exp_err});
    if (!exp_err) chk(rsp_data == 16'h0280, "R11", "fetch status", {16'd0, rsp_data}, 32'h0280);
    after_done();
  endtask

  initial begin
    int c;
    void'($urandom(32'h1D5E));
    repeat (3) @(negedge clk);
    chk(jtck == 0 && jtms == 1 && jtdi == 0 && jtclk == 1 && req_ready == 1 && rsp_done == 0,
        "R1", "pins in reset", {26'd0, jtck, jtms, jtdi, jtclk, req_ready, rsp_done}, 32'h1A);
    rst_n = 1;
    log_en = 1;
    @(negedge clk);
    chk(jtck == 0 && jtms == 1 && jtclk == 1 && req_ready == 1, "R1", "pins after reset",
        {28'd0, jtck, jtms, jtclk, req_ready}, 32'h7);
    // R5 TAP reset
    run_script(0, 0, 0, 0, "R5");
    chk(tms_ones == RONES && tck_edges == RONES + 1 && tst == RTI, "R5", "tms ones / edges",
        {8'd0, 8'(tms_ones), 8'(tck_edges), 4'd0, tst}, {8'd0, 8'(RONES), 8'(RONES+1), 8'(RTI)});
    run_script(1, 0, 0, 0, "R6");
    run_script(2, 0, 0, 0, "R7");
    run_script(4, 0, 16'hF00E, 0, "R8");
    run_script(5, 0, 16'h0200, 0, "R9");
    run_script(5, 1, 16'h0203, 0, "R9");
    run_script(6, 0, 16'h0210, 16'hBEEF, "R10");
    run_script(6, 1, 16'h0211, 16'h00A5, "R10");
    run_script(7, 0, 0, 0, "R13");
    run_fetch(0);
    run_fetch(PMAX - 1);
    run_fetch(PMAX);
    run_script(5, 0, 16'h0300, 0, "R14");   // error cleared on new request
    for (int n = 0; n < 24; n++) begin
      c = $urandom_range(1, 7);
      if (c == 3) run_fetch($urandom_range(0, 5));
      else run_script(c, 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
                      c == 5 ? "R9" : c == 6 ? "R10" : c == 4 ? "R8" : "R3");
    end
    chk(viol == 0, "R2", "tck phase / pin-change violations", 32'(viol), 0);
    chk(tst == RTI, "R4", "target ends in idle", {28'd0, tst}, {28'd0, RTI});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule